// File: doc/BRIEF.md
# Dual-Channel Sample Capture Buffer

This block records a burst of samples from two 8-bit converter channels into on-chip memory at a rate set by the host. The rate comes from a down-counter that runs on the fast reference clock. Each terminal count of that counter produces one sample strobe. On each strobe, both channels are written to the same location. One shared write address steps through 2048 locations. When the last location has been written, capture stops by itself and a done flag rises.

The host has two write operations on a small register port. A start write carries the divider value and begins a new capture. A pointer write selects the readback position and the channel to read. After capture, each host read returns one stored byte one cycle later and advances the read pointer. The memory address comes from the capture counter while a capture is running and from the host read pointer at all other times.

Top module: `dual_capture_buffer`

## Requirements
- R1: A start write loads the divider from host_wdata[15:0]. The effective divider D is the written value, or 2 when the value is below 2. The first sample_strobe is high in the D-th cycle after the start edge. After that, sample_strobe is high once every D reference cycles.
- R2: The divider accepts values up to 65535. This covers the divisors 38000, 3800, 380 and 38, which give 1 kHz, 10 kHz, 100 kHz and 1 MHz from a 38 MHz reference.
- R3: Channel 0 is carried on samples_in[7:0] and channel 1 on samples_in[15:8]. On each strobe edge, both channels' bytes are written to one shared address. The bytes written are the ones registered at the previous clock edge.
- R4: The write address is 0 after a start and rises by one on each strobe. After exactly 2048 strobes, busy falls and done rises on the same edge.
- R5: sample_strobe is never high while busy is low.
- R6: A start write (host_wr with host_sel = 0) sets busy and clears done. A start write during a running capture restarts it from address 0.
- R7: A pointer write (host_wr with host_sel = 1) sets the read pointer from host_wdata[10:0] and the channel from host_wdata[15] (0 selects channel 0, 1 selects channel 1). When busy is low, each host_rd cycle places the addressed byte on host_rdata in the following cycle and increments the pointer, wrapping from 2047 to 0.
- R8: While busy is high, a host_rd cycle returns 0 on host_rdata and leaves the read pointer unchanged.
- R9: After reset, busy, done, sample_strobe and host_rdata are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samples_in | input | 16 | Channel 1 byte in the upper half, channel 0 byte in the lower half |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | Write target: 0 is start with divider, 1 is read pointer and channel |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Byte read back, valid one cycle after host_rd |
| sample_strobe | output | 1 | High in the cycle whose closing edge stores a sample pair |
| busy | output | 1 | Capture in progress |
| done | output | 1 | The last capture filled the memory |

## Verification
sample_strobe is combinational from the divider count, so the bench samples it on the falling edge. It counts reference cycles from the start edge and expects the strobe at cycle D, and then every D cycles. The sample that a strobe stores was registered one edge before that strobe edge. For that reason the bench changes the channel inputs on the falling edge at which it sees the strobe, and each stored byte maps to exactly one ramp index. done is checked on the falling edge that follows the 2048th strobe. A read byte is checked on the falling edge that follows the read edge. Reads issued back to back therefore check one byte per cycle.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
   typedef enum logic {
      HSEL_START = 1'b0,
      HSEL_PTR   = 1'b1
   } host_sel_e;
endpackage

// File: rtl/capbuf_rate_div.sv
module capbuf_rate_div #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] div_load,
   output logic             tick,
   output logic [DIV_W-1:0] div_eff
);
   localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

   function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] v);
      return (v < MIN_DIV) ? MIN_DIV : v;
   endfunction

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt_q;

   assign div_eff = clamp_div(div_q);
   assign tick    = run && (cnt_q == '0) && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= MIN_DIV;
         cnt_q <= '0;
      end else if (restart) begin
         div_q <= div_load;
         cnt_q <= clamp_div(div_load) - DIV_W'(1);
      end else if (run) begin
         cnt_q <= (cnt_q == '0) ? (div_eff - DIV_W'(1)) : (cnt_q - DIV_W'(1));
      end
   end
endmodule

// File: rtl/capbuf_seq.sv
module capbuf_seq #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              tick,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] waddr
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         waddr <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         done  <= 1'b0;
         waddr <= '0;
      end else if (tick) begin
         waddr <= waddr + ADDR_W'(1);
         if (waddr == LAST_ADDR) begin
            busy <= 1'b0;
            done <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/capbuf_host_regs.sv
module capbuf_host_regs #(
   parameter int ADDR_W   = 11,
   parameter int CH_SEL_W = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ptr_wr,
   input  logic [ADDR_W-1:0]   ptr_val,
   input  logic [CH_SEL_W-1:0] chan_val,
   input  logic                host_rd,
   input  logic                busy,
   output logic [ADDR_W-1:0]   rptr,
   output logic [CH_SEL_W-1:0] chan_sel
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr     <= '0;
         chan_sel <= '0;
      end else if (ptr_wr) begin
         rptr     <= ptr_val;
         chan_sel <= chan_val;
      end else if (host_rd && !busy) begin
         rptr <= rptr + ADDR_W'(1);
      end
   end
endmodule

// File: rtl/capbuf_sample_store.sv
module capbuf_sample_store #(
   parameter int NUM_CH   = 2,
   parameter int SAMPLE_W = 8,
   parameter int ADDR_W   = 11,
   parameter int CH_SEL_W = 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_CH*SAMPLE_W-1:0]   samples_in,
   input  logic                         busy,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            waddr,
   input  logic                         rd_en,
   input  logic [ADDR_W-1:0]            rptr,
   input  logic [CH_SEL_W-1:0]          chan_sel,
   output logic [SAMPLE_W-1:0]          rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int MEM_W = NUM_CH * SAMPLE_W;

   logic [MEM_W-1:0]    mem [DEPTH];
   logic [MEM_W-1:0]    hold_q;
   logic [MEM_W-1:0]    mem_word;
   logic [ADDR_W-1:0]   mem_addr;
   logic [SAMPLE_W-1:0] lane [NUM_CH];
   logic [SAMPLE_W-1:0] lane_pick;

   assign mem_addr = busy ? waddr : rptr;
   assign mem_word = mem[mem_addr];

   for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hold_q[g*SAMPLE_W +: SAMPLE_W] <= '0;
         else        hold_q[g*SAMPLE_W +: SAMPLE_W] <= samples_in[g*SAMPLE_W +: SAMPLE_W];
      end
      assign lane[g] = mem_word[g*SAMPLE_W +: SAMPLE_W];
   end

   assign lane_pick = (int'(chan_sel) < NUM_CH) ? lane[chan_sel] : '0;

   always_ff @(posedge clk) begin
      if (wr_en) mem[mem_addr] <= hold_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= busy ? '0 : lane_pick;
   end
endmodule

// File: rtl/dual_capture_buffer.sv
module dual_capture_buffer
   import capbuf_pkg::*;
#(
   parameter int NUM_CH   = 2,
   parameter int SAMPLE_W = 8,
   parameter int ADDR_W   = 11,
   parameter int DIV_W    = 16,
   parameter int HOST_W   = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CH*SAMPLE_W-1:0] samples_in,
   input  logic                       host_wr,
   input  logic                       host_sel,
   input  logic [HOST_W-1:0]          host_wdata,
   input  logic                       host_rd,
   output logic [SAMPLE_W-1:0]        host_rdata,
   output logic                       sample_strobe,
   output logic                       busy,
   output logic                       done
);
   localparam int CH_SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH < 1 || SAMPLE_W < 1) begin : g_bad_lanes
      $error("capture buffer needs at least one channel of nonzero width");
   end
   if (DIV_W < 2 || DIV_W > HOST_W) begin : g_bad_div
      $error("divider width must lie between 2 and the host word width");
   end
   if (ADDR_W < 1 || ADDR_W + CH_SEL_W > HOST_W) begin : g_bad_ptr
      $error("pointer and channel fields must fit in the host word");
   end

   logic              start_pulse;
   logic              ptr_wr;
   logic [DIV_W-1:0]  div_eff;
   logic [ADDR_W-1:0] waddr;
   logic [ADDR_W-1:0] rptr;
   logic [CH_SEL_W-1:0] chan_sel;

   assign start_pulse = host_wr && (host_sel_e'(host_sel) == HSEL_START);
   assign ptr_wr      = host_wr && (host_sel_e'(host_sel) == HSEL_PTR);

   capbuf_rate_div #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .restart  (start_pulse),
      .div_load (host_wdata[DIV_W-1:0]),
      .tick     (sample_strobe),
      .div_eff  (div_eff)
   );

   capbuf_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start_pulse),
      .tick  (sample_strobe),
      .busy  (busy),
      .done  (done),
      .waddr (waddr)
   );

   capbuf_host_regs #(.ADDR_W(ADDR_W), .CH_SEL_W(CH_SEL_W)) u_host (
      .clk      (clk),
      .rst_n    (rst_n),
      .ptr_wr   (ptr_wr),
      .ptr_val  (host_wdata[ADDR_W-1:0]),
      .chan_val (host_wdata[HOST_W-1 -: CH_SEL_W]),
      .host_rd  (host_rd),
      .busy     (busy),
      .rptr     (rptr),
      .chan_sel (chan_sel)
   );

   capbuf_sample_store #(
      .NUM_CH   (NUM_CH),
      .SAMPLE_W (SAMPLE_W),
      .ADDR_W   (ADDR_W),
      .CH_SEL_W (CH_SEL_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .samples_in (samples_in),
      .busy       (busy),
      .wr_en      (sample_strobe),
      .waddr      (waddr),
      .rd_en      (host_rd),
      .rptr       (rptr),
      .chan_sel   (chan_sel),
      .rdata      (host_rdata)
   );
endmodule

// File: rtl/dual_capture_buffer_chk.sv
module dual_capture_buffer_chk #(
   parameter int SAMPLE_W = 8,
   parameter int ADDR_W   = 11,
   parameter int DIV_W    = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sample_strobe,
   input logic                busy,
   input logic                done,
   input logic                host_rd,
   input logic [SAMPLE_W-1:0] host_rdata,
   input logic                start_pulse,
   input logic [ADDR_W-1:0]   waddr,
   input logic [DIV_W-1:0]    div_eff
);
   logic [DIV_W:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           gap_q <= (DIV_W+1)'(1);
      else if (start_pulse || sample_strobe) gap_q <= (DIV_W+1)'(1);
      else if (busy)                         gap_q <= gap_q + (DIV_W+1)'(1);
   end

   // R1
   strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_strobe |-> (gap_q == {1'b0, div_eff}));

   // R5
   strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_strobe |-> busy);

   // R4
   waddr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_strobe |=> (waddr == $past(waddr) + ADDR_W'(1)));

   // R4
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);

   // R4
   done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(sample_strobe));

   // R6
   start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> (busy && !done && waddr == '0));

   // R8
   busy_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && busy) |=> (host_rdata == '0));
endmodule

bind dual_capture_buffer dual_capture_buffer_chk #(
   .SAMPLE_W (SAMPLE_W),
   .ADDR_W   (ADDR_W),
   .DIV_W    (DIV_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sample_strobe (sample_strobe),
   .busy          (busy),
   .done          (done),
   .host_rd       (host_rd),
   .host_rdata    (host_rdata),
   .start_pulse   (start_pulse),
   .waddr         (waddr),
   .div_eff       (div_eff)
);

// File: tb/dual_capture_buffer_test.sv
`timescale 1ns/1ps
module dual_capture_buffer_test;
   localparam int DEPTH = 2048;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] samples_in = '0;
   logic        host_wr = 1'b0;
   logic        host_sel = 1'b0;
   logic [15:0] host_wdata = '0;
   logic        host_rd = 1'b0;
   logic [7:0]  host_rdata;
   logic        sample_strobe;
   logic        busy;
   logic        done;

   int unsigned n_checks = 0;
   int unsigned n_errors = 0;
   bit          finished = 1'b0;
   int unsigned base_v [2];
   int unsigned step_v [2];

   always #2 clk = ~clk;

   dual_capture_buffer uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .samples_in    (samples_in),
      .host_wr       (host_wr),
      .host_sel      (host_sel),
      .host_wdata    (host_wdata),
      .host_rd       (host_rd),
      .host_rdata    (host_rdata),
      .sample_strobe (sample_strobe),
      .busy          (busy),
      .done          (done)
   );

   function automatic logic [7:0] ramp(input int ch, input int n);
      return 8'(base_v[ch] + step_v[ch] * n);
   endfunction

   function automatic int eff_div(input int d);
      return (d < 2) ? 2 : d;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic host_write(input bit sel, input logic [15:0] data);
      host_wr = 1'b1; host_sel = sel; host_wdata = data;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic set_ptr(input int ptr, input bit ch);
      host_write(1'b1, {ch, 4'b0, 11'(ptr)});
   endtask

   task automatic read_byte(output logic [7:0] v);
      host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
      v = host_rdata;
   endtask

   // Start, then count cycles to the first strobe only (R1, R2).
   task automatic gap_probe(input int d, input string req);
      int gap = 1;
      host_write(1'b0, 16'(d));
      while (!sample_strobe) begin
         @(negedge clk);
         gap++;
      end
      check(gap == eff_div(d), req, gap, eff_div(d));
   endtask

   task automatic run_capture(input int d, input bit probe);
      int gap = 1;
      int n = 0;
      int gap_err = 0;
      bit rd_pend = 1'b0;
      bit probed = 1'b0;
      base_v[0] = $urandom % 256; step_v[0] = 1 + $urandom % 7;
      base_v[1] = $urandom % 256; step_v[1] = 255 - ($urandom % 5);
      samples_in = {ramp(1, 0), ramp(0, 0)};
      host_write(1'b0, 16'(d));
      check(busy && !done, "R6 busy set, done clear after start", {busy, done}, 2);
      forever begin
         if (rd_pend) begin
            check(host_rdata == 8'd0, "R8 read during capture", host_rdata, 0);
            host_rd = 1'b0; rd_pend = 1'b0;
         end
         if (done) break;
         if (sample_strobe) begin
            if (gap != eff_div(d)) begin
               gap_err++;
               check(1'b0, "R1 strobe spacing", gap, eff_div(d));
            end
            if (!busy) check(1'b0, "R5 strobe while idle", busy, 1);
            n++;
            samples_in = {ramp(1, n), ramp(0, n)};
            gap = 1;
         end else begin
            gap++;
         end
         if (probe && !probed && n == 100 && !sample_strobe) begin
            host_rd = 1'b1; rd_pend = 1'b1; probed = 1'b1;
         end
         @(negedge clk);
      end
      check(gap_err == 0, "R1 all strobe gaps", gap_err, 0);
      check(n == DEPTH, "R4 sample count", n, DEPTH);
      check(!busy, "R4 busy low at done", busy, 0);
   endtask

   task automatic verify_channel(input bit ch, input string tag);
      logic [7:0] v;
      int bad = 0;
      set_ptr(0, ch);
      for (int i = 0; i < DEPTH; i++) begin
         read_byte(v);
         if (v !== ramp(ch, i)) begin
            bad++;
            check(1'b0, tag, v, ramp(ch, i));
         end
      end
      check(bad == 0, tag, bad, 0);
   endtask

   initial begin
      logic [7:0] v;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9
      check(!busy && !done && !sample_strobe && host_rdata == 0, "R9 reset state",
            {busy, done, sample_strobe, host_rdata}, 0);

      // R2: slow-rate divisors, first strobe spacing only
      gap_probe(38000, "R2 1 kHz divisor");
      gap_probe(3800,  "R2 10 kHz divisor");
      gap_probe(380,   "R2 100 kHz divisor");
      gap_probe(38,    "R2 1 MHz divisor");
      gap_probe(0,     "R1 divider 0 clamps to 2");

      // R6: restart while busy, then full capture at minimum divisor
      run_capture(1, 1'b0);
      verify_channel(1'b0, "R3 channel 0 data, divider 1");
      verify_channel(1'b1, "R3 channel 1 data, divider 1");

      // R8: pointer preset before capture must survive busy reads
      set_ptr(7, 1'b1);
      run_capture(3, 1'b1);
      read_byte(v);
      check(v == ramp(1, 7), "R8 pointer untouched by busy read", v, ramp(1, 7));
      read_byte(v);
      check(v == ramp(1, 8), "R7 pointer increments", v, ramp(1, 8));
      verify_channel(1'b0, "R3 channel 0 data, divider 3");
      verify_channel(1'b1, "R3 channel 1 data, divider 3");

      // R7: wrap and random spot reads
      set_ptr(DEPTH - 1, 1'b0);
      read_byte(v);
      check(v == ramp(0, DEPTH - 1), "R7 last address", v, ramp(0, DEPTH - 1));
      read_byte(v);
      check(v == ramp(0, 0), "R7 pointer wraps", v, ramp(0, 0));
      for (int k = 0; k < 8; k++) begin
         int p = $urandom % DEPTH;
         bit c = 1'($urandom % 2);
         set_ptr(p, c);
         read_byte(v);
         check(v == ramp(c, p), "R7 random spot read", v, ramp(c, p));
      end

      run_capture(4 + $urandom % 3, 1'b0);
      verify_channel(1'b0, "R3 channel 0 data, random divider");
      verify_channel(1'b1, "R3 channel 1 data, random divider");
      check(done, "R4 done holds after readback", done, 1);

      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      #(4 * 195000);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog expired, actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end
endmodule